// File: doc/BRIEF.md
# General-Purpose Pin Bank with Per-Pin Interrupt Detection

A bank of sixteen general-purpose pins behind a 16-bit register port. Software configures each pin as input or output, or hands the pad over to an alternate function; it writes output levels and reads back the pin state. Every pin has its own interrupt detector. The detector can watch for a rising or falling edge, or for a high or low level. It has a sticky status bit and a per-pin mask, and the bank raises one combined interrupt line.

Two system conditions override the pin outputs. While `sleep_i` is high, every pin drives its bit from a sleep-level register. While `batt_fault_i` is high, every pin drives its bit from a fault-level register, and a fault takes precedence over sleep. Interrupt detection can be suppressed per pin for the duration of sleep. Pad inputs cross into the clock domain through a two-stage synchronizer. Edges are detected on the synchronized value.

Top module: `gpio_bank_irq`

## Requirements
- R1: While reset is held, every register reads 0 except the mask register (offset 0x00), which reads 0xFFFF. `pad_oe` and `irq_o` are 0.
- R2: A pin with direction bit 1 (offset 0x02) and alternate bit 0 has `pad_oe` 1. A pin with direction 0 has `pad_oe` 0. With no override active, `pad_out` equals the output-data register (offset 0x04).
- R3: `alt_sel` equals the alternate register (offset 0x14), where 1 hands the pin to the alternate function. A pin with alternate bit 1 has `pad_oe` 0.
- R4: The pin-read register (offset 0x18) returns the synchronized pad input for pins with direction 0, and the driven `pad_out` value for pins with direction 1.
- R5: With trigger type 1 (offset 0x06), a pin's status bit sets on a rising pad edge when edge select (offset 0x08) is 1, and on a falling edge when it is 0. The opposite edge does not set it. The status bit becomes visible on the third rising clock edge after the pad changes.
- R6: With trigger type 0, the status bit sets while the synchronized pad equals the level-select bit (offset 0x0A): 1 for high, 0 for low. A clear is overridden at once while the level persists.
- R7: A status bit (offset 0x12) stays set until software writes 0 to it. Writing 1 to a status bit leaves it unchanged.
- R8: `irq_o` is the OR of the status bits whose mask bit is 0. Mask 1 blocks only the line, and the status bit still sets.
- R9: While `sleep_i` is high, a pin whose sleep-trigger bit (offset 0x0C) is 1 cannot set its status bit. Pins with 0 in that register keep detecting.
- R10: While `sleep_i` is high and `batt_fault_i` is low, `pad_out` equals the sleep-level register (offset 0x0E).
- R11: While `batt_fault_i` is high, `pad_out` equals the fault-level register (offset 0x10), whether or not sleep is active.
- R12: Registers sit at even byte offsets; the configuration register at 0x16 is plain read/write storage. A write to an odd address or to an offset beyond 0x18 changes nothing. A read of either returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on `reg_addr` |
| pad_in | input | 16 | Pad input levels, asynchronous |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| alt_sel | output | 16 | Per-pin alternate-function select |
| sleep_i | input | 1 | Sleep condition |
| batt_fault_i | input | 1 | Battery-fault condition |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle. A status bit never drops without a clearing write and never rises without a detected event. A clearing write with no event leaves only the kept bits set. A sleep-suppressed pin never sets its bit during sleep. An alternate pin never has its output enabled, and a battery fault always forces the fault levels onto `pad_out`.

Other behaviour can only be shown by the bench's scenarios. These cover:
- the exact three-edge latency, and the choice between edge and level detection and of polarity, swept over all sixteen pins;
- a level re-asserting after a clear;
- the mask blocking only the line;
- the pin-read mixing of input and output values;
- the address decode.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // Word index (byte offset / 2) of each register; software-visible map.
   typedef enum logic [3:0] {
      RI_MASK   = 4'd0,
      RI_DIR    = 4'd1,
      RI_DOUT   = 4'd2,
      RI_TTYPE  = 4'd3,
      RI_ESEL   = 4'd4,
      RI_LSEL   = 4'd5,
      RI_SLPDIS = 4'd6,
      RI_SLPOUT = 4'd7,
      RI_BFOUT  = 4'd8,
      RI_STAT   = 4'd9,
      RI_ALT    = 4'd10,
      RI_CFG    = 4'd11,
      RI_PIN    = 4'd12
   } reg_idx_e;

   // Number of slots in the stored-register array (status slot is a placeholder).
   localparam int NSTORE = int'(RI_CFG) + 1;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NPIN = 16,
   parameter int DW   = 16,
   parameter int AW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   input  logic [NPIN-1:0] stat_i,
   input  logic [NPIN-1:0] pin_i,
   output logic [NPIN-1:0] cfg_o [NSTORE],
   output logic            stat_clr_o,
   output logic [NPIN-1:0] stat_keep_o,
   output logic [DW-1:0]   rdata
);
   localparam int WIW = AW - 1;

   logic [WIW-1:0] widx;
   logic           aligned;

   assign widx    = addr[AW-1:1];
   assign aligned = ~addr[0];

   // One storage slot per configuration register; the status slot is empty.
   for (genvar g = 0; g < NSTORE; g++) begin : g_slot
      if (g == int'(RI_STAT)) begin : g_hole
         assign cfg_o[g] = '0;
      end else begin : g_reg
         localparam logic [NPIN-1:0] RST_VAL = (g == int'(RI_MASK)) ? '1 : '0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg_o[g] <= RST_VAL;
            end else if (wr_en && aligned && (widx == WIW'(g))) begin
               cfg_o[g] <= wdata[NPIN-1:0];
            end
         end
      end
   end

   assign stat_clr_o  = wr_en && aligned && (widx == WIW'(RI_STAT));
   assign stat_keep_o = wdata[NPIN-1:0];

   always_comb begin
      rdata = '0;
      if (aligned) begin
         for (int g = 0; g < NSTORE; g++) begin
            if ((widx == WIW'(g)) && (g != int'(RI_STAT))) rdata = DW'(cfg_o[g]);
         end
         if (widx == WIW'(RI_STAT)) rdata = DW'(stat_i);
         if (widx == WIW'(RI_PIN))  rdata = DW'(pin_i);
      end
   end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_bank_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st[s] <= '0;
      end else begin
         st[0] <= d_i;
         for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      end
   end

   assign q_o = st[STAGES-1];
endmodule

// File: rtl/gpio_bank_irq_det.sv
module gpio_bank_irq_det #(
   parameter int NPIN = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] lvl_i,
   input  logic [NPIN-1:0] ttype_i,
   input  logic [NPIN-1:0] esel_i,
   input  logic [NPIN-1:0] lsel_i,
   input  logic [NPIN-1:0] slpdis_i,
   input  logic            sleep_i,
   input  logic            clr_we_i,
   input  logic [NPIN-1:0] clr_keep_i,
   output logic [NPIN-1:0] stat_o
);
   logic [NPIN-1:0] prev_q;
   logic [NPIN-1:0] evt;
   logic [NPIN-1:0] stat_q;
   logic [NPIN-1:0] stat_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   for (genvar g = 0; g < NPIN; g++) begin : g_pin
      logic rise, fall, edge_hit, lvl_hit, hit;
      always_comb begin
         rise     = lvl_i[g] & ~prev_q[g];
         fall     = ~lvl_i[g] & prev_q[g];
         edge_hit = esel_i[g] ? rise : fall;
         lvl_hit  = (lvl_i[g] == lsel_i[g]);
         hit      = ttype_i[g] ? edge_hit : lvl_hit;
         evt[g]   = hit & ~(sleep_i & slpdis_i[g]);
      end
   end

   // A new event wins over a clear in the same cycle.
   always_comb begin
      stat_d = clr_we_i ? (stat_q & clr_keep_i) : stat_q;
      stat_d = stat_d | evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assign stat_o = stat_q;

   // R7
   stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R7
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && (evt == '0)) |=> ((stat_q & ~$past(clr_keep_i)) == '0));

   // R5
   stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));

   // R9
   slp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> ((stat_q & ~$past(stat_q) & $past(slpdis_i)) == '0));
endmodule

// File: rtl/gpio_bank_outmux.sv
module gpio_bank_outmux #(
   parameter int NPIN = 16
) (
   input  logic [NPIN-1:0] dout_i,
   input  logic [NPIN-1:0] slpout_i,
   input  logic [NPIN-1:0] bfout_i,
   input  logic [NPIN-1:0] dir_i,
   input  logic [NPIN-1:0] alt_i,
   input  logic [NPIN-1:0] lvl_i,
   input  logic            sleep_i,
   input  logic            bf_i,
   output logic [NPIN-1:0] pad_out_o,
   output logic [NPIN-1:0] pad_oe_o,
   output logic [NPIN-1:0] pin_rd_o
);
   for (genvar g = 0; g < NPIN; g++) begin : g_pin
      always_comb begin
         if (bf_i)         pad_out_o[g] = bfout_i[g];
         else if (sleep_i) pad_out_o[g] = slpout_i[g];
         else              pad_out_o[g] = dout_i[g];
         pad_oe_o[g] = dir_i[g] & ~alt_i[g];
         pin_rd_o[g] = dir_i[g] ? pad_out_o[g] : lvl_i[g];
      end
   end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
   import gpio_bank_pkg::*;
#(
   parameter int NPIN        = 16,
   parameter int DW          = 16,
   parameter int AW          = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   input  logic [NPIN-1:0] pad_in,
   output logic [NPIN-1:0] pad_out,
   output logic [NPIN-1:0] pad_oe,
   output logic [NPIN-1:0] alt_sel,
   input  logic            sleep_i,
   input  logic            batt_fault_i,
   output logic            irq_o
);
   if ((NPIN < 1) || (NPIN > DW)) begin : g_bad_npin
      $error("gpio_bank_irq: NPIN must be 1..DW");
   end
   if (AW < 5) begin : g_bad_aw
      $error("gpio_bank_irq: AW must cover the 0x18 offset");
   end

   logic [NPIN-1:0] cfg_w [NSTORE];
   logic [NPIN-1:0] lvl_w;
   logic [NPIN-1:0] stat_w;
   logic [NPIN-1:0] pin_rd_w;
   logic [NPIN-1:0] keep_w;
   logic            clr_w;

   gpio_bank_regs #(.NPIN(NPIN), .DW(DW), .AW(AW)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .stat_i     (stat_w),
      .pin_i      (pin_rd_w),
      .cfg_o      (cfg_w),
      .stat_clr_o (clr_w),
      .stat_keep_o(keep_w),
      .rdata      (reg_rdata)
   );

   gpio_bank_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pad_in),
      .q_o  (lvl_w)
   );

   gpio_bank_irq_det #(.NPIN(NPIN)) det_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_i     (lvl_w),
      .ttype_i   (cfg_w[RI_TTYPE]),
      .esel_i    (cfg_w[RI_ESEL]),
      .lsel_i    (cfg_w[RI_LSEL]),
      .slpdis_i  (cfg_w[RI_SLPDIS]),
      .sleep_i   (sleep_i),
      .clr_we_i  (clr_w),
      .clr_keep_i(keep_w),
      .stat_o    (stat_w)
   );

   gpio_bank_outmux #(.NPIN(NPIN)) omux_i (
      .dout_i   (cfg_w[RI_DOUT]),
      .slpout_i (cfg_w[RI_SLPOUT]),
      .bfout_i  (cfg_w[RI_BFOUT]),
      .dir_i    (cfg_w[RI_DIR]),
      .alt_i    (cfg_w[RI_ALT]),
      .lvl_i    (lvl_w),
      .sleep_i  (sleep_i),
      .bf_i     (batt_fault_i),
      .pad_out_o(pad_out),
      .pad_oe_o (pad_oe),
      .pin_rd_o (pin_rd_w)
   );

   assign alt_sel = cfg_w[RI_ALT];
   assign irq_o   = |(stat_w & ~cfg_w[RI_MASK]);

   // R3
   alt_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & alt_sel) == '0));

   // R11
   bf_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      batt_fault_i |-> (pad_out == cfg_w[RI_BFOUT]));
endmodule

// File: tb/gpio_bank_irq_tb_top.sv
module gpio_bank_irq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe, alt_sel;
   logic        sleep_i = 1'b0;
   logic        batt_fault_i = 1'b0;
   logic        irq_o;

   int nchk = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   gpio_bank_irq dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel),
      .sleep_i(sleep_i), .batt_fault_i(batt_fault_i), .irq_o(irq_o)
   );

   localparam logic [4:0] A_MASK = 5'h00, A_DIR = 5'h02, A_DOUT = 5'h04,
      A_TTYPE = 5'h06, A_ESEL = 5'h08, A_LSEL = 5'h0A, A_SLPDIS = 5'h0C,
      A_SLPOUT = 5'h0E, A_BFOUT = 5'h10, A_STAT = 5'h12, A_ALT = 5'h14,
      A_CFG = 5'h16, A_PIN = 5'h18;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      // R1: reset state sampled while reset is held
      idle(3);
      for (int a = 0; a <= 12; a++) begin
         rd(5'(2 * a), v);
         chk("R1 reset register", v, (a == 0) ? 16'hFFFF : 16'h0000);
      end
      chk("R1 reset pad_oe", pad_oe, 16'h0);
      chk("R1 reset irq", {15'h0, irq_o}, 16'h0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R12: read/write storage and address decode
      for (int a = 0; a <= 11; a++) begin
         if (a == 9) continue;
         wr(5'(2 * a), 16'h3C5A ^ (16'(a) * 16'h0101));
      end
      for (int a = 0; a <= 11; a++) begin
         if (a == 9) continue;
         rd(5'(2 * a), v);
         chk("R12 readback", v, 16'h3C5A ^ (16'(a) * 16'h0101));
      end
      wr(5'h03, 16'hFFFF);
      rd(A_DIR, v);
      chk("R12 odd write ignored", v, 16'h3C5A ^ 16'h0101);
      rd(5'h03, v);
      chk("R12 odd read zero", v, 16'h0);
      wr(5'h1A, 16'hFFFF);
      rd(5'h1A, v);
      chk("R12 unused read zero", v, 16'h0);
      for (int a = 0; a <= 11; a++) begin
         if (a == 9) continue;
         rd(5'(2 * a), v);
         chk("R12 unused write ignored", v, 16'h3C5A ^ (16'(a) * 16'h0101));
      end

      // R2, R3, R4: direction, data, alternate, pin read
      wr(A_DIR, 16'h00FF); wr(A_DOUT, 16'h0F0F); wr(A_ALT, 16'h0003);
      pad_in = 16'hA5A5;
      idle(3);
      chk("R2 pad_oe", pad_oe, 16'h00FC);
      chk("R2 pad_out", pad_out, 16'h0F0F);
      chk("R3 alt_sel", alt_sel, 16'h0003);
      rd(A_PIN, v);
      chk("R4 pin read mix", v, (16'hA5A5 & 16'hFF00) | (16'h0F0F & 16'h00FF));
      wr(A_DIR, 16'h0000); wr(A_ALT, 16'h0000);
      chk("R2 inputs not driven", pad_oe, 16'h0);

      // R5..R8: sweep all pins over the four detection modes
      wr(A_SLPDIS, 16'h0);
      wr(A_MASK, 16'h0);
      for (int m = 0; m < 4; m++) begin
         logic [15:0] base;
         base = (m == 0 || m == 2) ? 16'h0000 : 16'hFFFF;
         wr(A_TTYPE, (m < 2) ? 16'hFFFF : 16'h0000);
         wr(A_ESEL, (m == 0) ? 16'hFFFF : 16'h0000);
         wr(A_LSEL, (m == 2) ? 16'hFFFF : 16'h0000);
         for (int i = 0; i < 16; i++) begin
            logic [15:0] bit_i;
            bit_i = 16'h1 << i;
            pad_in = base;
            idle(4);
            wr(A_STAT, 16'h0);
            rd(A_STAT, v);
            chk((m < 2) ? "R5 idle no status" : "R6 idle no status", v, 16'h0);
            @(negedge clk); pad_in = base ^ bit_i;
            idle(2);
            rd(A_STAT, v);
            chk("R5 latency not before third edge", v, 16'h0);
            chk("R8 irq low before event", {15'h0, irq_o}, 16'h0);
            idle(1);
            rd(A_STAT, v);
            chk((m < 2) ? "R5 edge sets status" : "R6 level sets status", v, bit_i);
            chk("R8 irq high", {15'h0, irq_o}, 16'h1);
            wr(A_MASK, bit_i);
            chk("R8 masked irq low", {15'h0, irq_o}, 16'h0);
            rd(A_STAT, v);
            chk("R8 status set while masked", v, bit_i);
            wr(A_MASK, 16'h0);
            wr(A_STAT, 16'hFFFF);
            rd(A_STAT, v);
            chk("R7 write one keeps status", v, bit_i);
            wr(A_STAT, ~bit_i);
            rd(A_STAT, v);
            if (m < 2) chk("R7 write zero clears", v, 16'h0);
            else       chk("R6 level re-asserts after clear", v, bit_i);
            pad_in = base;
            idle(4);
            if (m < 2) begin
               rd(A_STAT, v);
               chk("R5 opposite edge ignored", v, 16'h0);
            end
         end
      end

      // R9: sleep trigger disable
      wr(A_TTYPE, 16'hFFFF); wr(A_ESEL, 16'hFFFF); wr(A_SLPDIS, 16'h00FF);
      pad_in = 16'h0; idle(4); wr(A_STAT, 16'h0);
      sleep_i = 1'b1;
      @(negedge clk); pad_in = 16'h0101;
      idle(4);
      rd(A_STAT, v);
      chk("R9 sleep blocks disabled pin only", v, 16'h0100);
      sleep_i = 1'b0;
      pad_in = 16'h0; idle(4); wr(A_STAT, 16'h0);
      @(negedge clk); pad_in = 16'h0001;
      idle(4);
      rd(A_STAT, v);
      chk("R9 awake pin detects", v, 16'h0001);

      // R10, R11: output override sweep
      wr(A_DIR, 16'hFFFF); wr(A_ALT, 16'h0);
      for (int p = 0; p < 4; p++) begin
         logic [15:0] dv, sv, bv;
         dv = 16'h1234 ^ (16'(p) * 16'h1111);
         sv = ~dv ^ (16'(p) << 4);
         bv = dv ^ 16'h5A5A;
         wr(A_DOUT, dv); wr(A_SLPOUT, sv); wr(A_BFOUT, bv);
         for (int c = 0; c < 4; c++) begin
            logic [15:0] ev;
            @(negedge clk);
            sleep_i = c[0]; batt_fault_i = c[1];
            #1;
            ev = c[1] ? bv : (c[0] ? sv : dv);
            if (c[1])      chk("R11 fault levels win", pad_out, ev);
            else if (c[0]) chk("R10 sleep levels", pad_out, ev);
            else           chk("R2 data levels", pad_out, ev);
            rd(A_PIN, v);
            chk("R4 pin read follows driven value", v, ev);
         end
         sleep_i = 1'b0; batt_fault_i = 1'b0;
      end

      finish_run();
   end
endmodule